// File: doc/BRIEF.md
# Synchronous Burst SRAM Command and Byte-Write Decoder

This block sits behind the control pins of a synchronous burst SRAM. On every rising clock edge it samples three chip selects, two address strobes (one from a host processor, one from a cache controller), the burst-step input, a global write input, a lane-write gate and one write enable per byte lane. From these it classifies the cycle into one of seven operations: deselect, begin read, begin write, continue read, continue write, suspend read or suspend write.

For that cycle it drives four registered outputs in the next clock cycle. The first is a one-hot operation code. The second is a strobe that tells the address path to load the external address. The third is a strobe that tells the burst counter to step. The fourth is a per-lane write mask for the array. A begin operation opens a burst and a deselect closes it. Continue and suspend cycles report deselect while no burst is open, so after reset the block reports deselect until the first accepted strobe.

Top module: `sram_cmd_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `op_oh` = deselect (bit 0), `load_addr` = 0, `step_addr` = 0 and `wr_mask` = 0. After reset, every cycle without an accepted strobe reports deselect until a begin operation occurs.
- R2: `op_oh` always has exactly one bit set. The bit positions are: 0 deselect, 1 begin read, 2 begin write, 3 continue read, 4 continue write, 5 suspend read, 6 suspend write.
- R3: `strb_host_n` low with `sel_a_n` low and the chip enabled gives a begin read, with `load_addr` = 1 and `wr_mask` = 0, whatever the write inputs are. This case takes priority over the controller strobe.
- R4: The chip counts as enabled only when `sel_b` is high and `sel_c_n` is low. An accepted strobe in a cycle where the chip is not enabled gives a deselect.
- R5: `sel_a_n` high blocks the host strobe. `sel_a_n` high together with `strb_ctrl_n` low gives a deselect.
- R6: `strb_ctrl_n` low, with the host strobe not accepted, `sel_a_n` low and the chip enabled, gives a begin write if any lane is written and a begin read otherwise. `load_addr` = 1 in both cases.
- R7: With no accepted strobe and a burst open, `step_n` low gives a continue operation with `step_addr` = 1, and `step_n` high gives a suspend operation. Each is a write if any lane is written and a read otherwise. With no burst open, such a cycle is a deselect.
- R8: `all_wr_n` low writes all lanes (`wr_mask` all ones), whatever the lane inputs are.
- R9: With `all_wr_n` high and `lane_gate_n` low, `wr_mask[i]` = ~`lane_wr_n[i]`. If no lane input is low, the cycle is a read. `wr_mask` is nonzero only on write operations.
- R10: With both `all_wr_n` and `lane_gate_n` high, the cycle is a read and `wr_mask` = 0.
- R11: Outputs change only at the rising edge after the inputs are sampled. Driving new inputs does not change the outputs before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sel_a_n | input | 1 | Chip select A, active low; masks the host strobe |
| sel_b | input | 1 | Chip select B, active high |
| sel_c_n | input | 1 | Chip select C, active low |
| strb_host_n | input | 1 | Host address strobe, active low |
| strb_ctrl_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst step request, active low |
| all_wr_n | input | 1 | Global write, active low |
| lane_gate_n | input | 1 | Enables per-lane writes, active low |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| op_oh | output | 7 | One-hot operation code |
| load_addr | output | 1 | Load external address strobe |
| step_addr | output | 1 | Burst counter step strobe |
| wr_mask | output | LANES | Lanes written this cycle |

## Verification
The only internal state is the open-burst flag. If that flag is wrong, the error shows at the ports in the cycle after the next strobe-free cycle. There a continue or suspend appears where a deselect is expected, or the reverse, along with a wrong `step_addr`. A misdecoded select, strobe priority or lane gate shows up one cycle after sampling as a wrong `op_oh` bit or `wr_mask` value. The bench sweeps every combination of the control inputs twice, in two different orders, so the flag meets each vector both open and closed.

// File: rtl/sramdec_pkg.sv
package sramdec_pkg;

    localparam int OPS = 7;

    typedef enum logic [2:0] {
        K_DSL = 3'd0,
        K_BRD = 3'd1,
        K_BWR = 3'd2,
        K_CRD = 3'd3,
        K_CWR = 3'd4,
        K_SRD = 3'd5,
        K_SWR = 3'd6
    } kind_e;

    function automatic logic is_begin(kind_e k);
        return (k == K_BRD) || (k == K_BWR);
    endfunction

    function automatic logic is_write(kind_e k);
        return (k == K_BWR) || (k == K_CWR) || (k == K_SWR);
    endfunction

    function automatic logic is_step(kind_e k);
        return (k == K_CRD) || (k == K_CWR);
    endfunction

    function automatic logic [OPS-1:0] to_onehot(kind_e k);
        logic [OPS-1:0] v;
        v = '0;
        v[k] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/sdec_lane_mask.sv
module sdec_lane_mask #(
    parameter int LANES = 4
) (
    input  logic             all_wr_n,
    input  logic             lane_gate_n,
    input  logic [LANES-1:0] lane_wr_n,
    output logic [LANES-1:0] raw_mask,
    output logic             wr_req
);
    // Each lane: written by the global write, or by its own enable when gated in.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign raw_mask[i] = ~all_wr_n | (~lane_gate_n & ~lane_wr_n[i]);
    end

    assign wr_req = |raw_mask;
endmodule

// File: rtl/sdec_classify.sv
module sdec_classify
    import sramdec_pkg::*;
(
    input  logic  sel_a_n,
    input  logic  sel_b,
    input  logic  sel_c_n,
    input  logic  strb_host_n,
    input  logic  strb_ctrl_n,
    input  logic  step_n,
    input  logic  wr_req,
    input  logic  burst_open,
    output kind_e kind
);
    logic chip_on;
    logic host_take;

    assign chip_on   = sel_b & ~sel_c_n;
    assign host_take = ~strb_host_n & ~sel_a_n;

    always_comb begin
        if (host_take) begin
            kind = chip_on ? K_BRD : K_DSL;
        end else if (!strb_ctrl_n) begin
            if (sel_a_n || !chip_on)
                kind = K_DSL;
            else
                kind = wr_req ? K_BWR : K_BRD;
        end else if (!burst_open) begin
            kind = K_DSL;
        end else if (!step_n) begin
            kind = wr_req ? K_CWR : K_CRD;
        end else begin
            kind = wr_req ? K_SWR : K_SRD;
        end
    end
endmodule

// File: rtl/sdec_out_reg.sv
module sdec_out_reg
    import sramdec_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  kind_e            kind,
    input  logic [LANES-1:0] raw_mask,
    output logic             burst_open,
    output logic [OPS-1:0]   op_oh,
    output logic             load_addr,
    output logic             step_addr,
    output logic [LANES-1:0] wr_mask
);
    always_ff @(posedge clk) begin
        if (rst) begin
            burst_open <= 1'b0;
            op_oh      <= to_onehot(K_DSL);
            load_addr  <= 1'b0;
            step_addr  <= 1'b0;
            wr_mask    <= '0;
        end else begin
            if (is_begin(kind))
                burst_open <= 1'b1;
            else if (kind == K_DSL)
                burst_open <= 1'b0;
            op_oh     <= to_onehot(kind);
            load_addr <= is_begin(kind);
            step_addr <= is_step(kind);
            wr_mask   <= is_write(kind) ? raw_mask : '0;
        end
    end
endmodule

// File: rtl/sram_cmd_decoder.sv
module sram_cmd_decoder
    import sramdec_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_a_n,
    input  logic             sel_b,
    input  logic             sel_c_n,
    input  logic             strb_host_n,
    input  logic             strb_ctrl_n,
    input  logic             step_n,
    input  logic             all_wr_n,
    input  logic             lane_gate_n,
    input  logic [LANES-1:0] lane_wr_n,
    output logic [OPS-1:0]   op_oh,
    output logic             load_addr,
    output logic             step_addr,
    output logic [LANES-1:0] wr_mask
);
    logic [LANES-1:0] raw_mask;
    logic             wr_req;
    logic             burst_open;
    kind_e            kind;

    sdec_lane_mask #(.LANES(LANES)) u_mask (
        .all_wr_n    (all_wr_n),
        .lane_gate_n (lane_gate_n),
        .lane_wr_n   (lane_wr_n),
        .raw_mask    (raw_mask),
        .wr_req      (wr_req)
    );

    sdec_classify u_cls (
        .sel_a_n     (sel_a_n),
        .sel_b       (sel_b),
        .sel_c_n     (sel_c_n),
        .strb_host_n (strb_host_n),
        .strb_ctrl_n (strb_ctrl_n),
        .step_n      (step_n),
        .wr_req      (wr_req),
        .burst_open  (burst_open),
        .kind        (kind)
    );

    sdec_out_reg #(.LANES(LANES)) u_reg (
        .clk        (clk),
        .rst        (rst),
        .kind       (kind),
        .raw_mask   (raw_mask),
        .burst_open (burst_open),
        .op_oh      (op_oh),
        .load_addr  (load_addr),
        .step_addr  (step_addr),
        .wr_mask    (wr_mask)
    );
endmodule

// File: rtl/sdec_chk.sv
module sdec_chk
    import sramdec_pkg::*;
#(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             sel_a_n,
    input logic             sel_b,
    input logic             sel_c_n,
    input logic             strb_host_n,
    input logic             strb_ctrl_n,
    input logic             step_n,
    input logic             all_wr_n,
    input logic             lane_gate_n,
    input logic [LANES-1:0] lane_wr_n,
    input logic [OPS-1:0]   op_oh,
    input logic             load_addr,
    input logic             step_addr,
    input logic [LANES-1:0] wr_mask
);
    localparam logic [OPS-1:0] OH_DSL = 7'b0000001;
    localparam logic [OPS-1:0] OH_BRD = 7'b0000010;
    localparam logic [OPS-1:0] OH_BWR = 7'b0000100;
    localparam logic [OPS-1:0] OH_STP = 7'b0011000;
    localparam logic [OPS-1:0] OH_WRS = 7'b1010100;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (op_oh == OH_DSL && !load_addr && !step_addr && wr_mask == '0));

    // R2
    onehot_op_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(op_oh) == 1);

    // R3
    host_read_chk: assert property (@(posedge clk) disable iff (rst)
        (!strb_host_n && !sel_a_n && sel_b && !sel_c_n)
        |=> (op_oh == OH_BRD && load_addr && wr_mask == '0));

    // R5
    sel_block_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_a_n && !strb_ctrl_n) |=> (op_oh == OH_DSL && !load_addr));

    // R8
    global_write_chk: assert property (@(posedge clk) disable iff (rst)
        (!all_wr_n && strb_host_n && !strb_ctrl_n && !sel_a_n && sel_b && !sel_c_n)
        |=> (op_oh == OH_BWR && wr_mask == '1));

    // R7
    step_op_chk: assert property (@(posedge clk) disable iff (rst)
        step_addr |-> ((op_oh & OH_STP) != '0));

    // R9
    mask_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_mask != '0) |-> ((op_oh & OH_WRS) != '0));
endmodule

bind sram_cmd_decoder sdec_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/sim_sram_cmd_decoder.sv
module sim_sram_cmd_decoder;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
    logic       strb_host_n = 1'b1, strb_ctrl_n = 1'b1, step_n = 1'b1;
    logic       all_wr_n = 1'b1, lane_gate_n = 1'b1;
    logic [3:0] lane_wr_n = 4'hF;
    logic [6:0] op_oh;
    logic       load_addr, step_addr;
    logic [3:0] wr_mask;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit open_m = 1'b0;

    always #4ns clk = ~clk;

    sram_cmd_decoder #(.LANES(4)) u0 (
        .clk(clk), .rst(rst),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .strb_host_n(strb_host_n), .strb_ctrl_n(strb_ctrl_n), .step_n(step_n),
        .all_wr_n(all_wr_n), .lane_gate_n(lane_gate_n), .lane_wr_n(lane_wr_n),
        .op_oh(op_oh), .load_addr(load_addr), .step_addr(step_addr), .wr_mask(wr_mask)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(logic [11:0] v);
        sel_a_n     = v[0];
        sel_b       = v[1];
        sel_c_n     = v[2];
        strb_host_n = v[3];
        strb_ctrl_n = v[4];
        step_n      = v[5];
        all_wr_n    = v[6];
        lane_gate_n = v[7];
        lane_wr_n   = v[11:8];
    endtask

    // Expected outputs from the requirements; updates the bench's burst flag.
    task automatic predict_and_check();
        logic [3:0] m;
        int         k;
        string      tag, mtag;
        logic       en;
        en = sel_b && !sel_c_n;
        if (!all_wr_n) begin m = 4'hF; mtag = "R8"; end
        else if (!lane_gate_n) begin m = ~lane_wr_n; mtag = "R9"; end
        else begin m = 4'h0; mtag = "R10"; end
        if (!strb_host_n && !sel_a_n) begin
            k = en ? 1 : 0; tag = en ? "R3" : "R4";
        end else if (!strb_ctrl_n) begin
            if (sel_a_n) begin k = 0; tag = "R5"; end
            else if (!en) begin k = 0; tag = "R4"; end
            else begin k = (m != 0) ? 2 : 1; tag = "R6"; end
        end else if (!open_m) begin
            k = 0; tag = "R7";
        end else begin
            k = (step_n ? 5 : 3) + ((m != 0) ? 1 : 0); tag = "R7";
        end
        if (k == 1 || k == 2) open_m = 1'b1;
        else if (k == 0) open_m = 1'b0;
        @(negedge clk);
        check(tag, {7'd0, op_oh, load_addr, step_addr},
              {7'd0, 7'(1 << k), (k == 1 || k == 2), (k == 3 || k == 4)});
        check("R2", 16'($countones(op_oh)), 16'd1);
        check(mtag, {12'd0, wr_mask}, {12'd0, (k == 2 || k == 4 || k == 6) ? m : 4'h0});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", {7'd0, op_oh, load_addr, step_addr}, {7'd0, 7'b0000001, 1'b0, 1'b0});
        check("R1", {12'd0, wr_mask}, 16'd0);
        rst = 1'b0;
        // R1: strobe-free cycles after reset stay deselect (step requested)
        apply(12'hFDF);
        predict_and_check();
        predict_and_check();
        // R11: begin write via controller strobe, outputs must hold until the edge
        apply({4'b1010, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0});
        #1ns;
        check("R11", {7'd0, op_oh, load_addr, step_addr}, {7'd0, 7'b0000001, 1'b0, 1'b0});
        predict_and_check();
        // R7: continue then suspend write inside the burst
        apply({4'b0110, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1});
        predict_and_check();
        apply({4'b0110, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1});
        predict_and_check();
        // Exhaustive sweeps in two orders
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < 4096; i++) begin
                logic [11:0] v;
                v = (p == 0) ? 12'(i) : (12'(4095 - i) ^ 12'hA5A);
                apply(v);
                predict_and_check();
            end
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule